// File: doc/BRIEF.md
# Parallel-ATA Device Interrupt Handshake Controller

This block is the device-side control machine of one drive sitting on a parallel-ATA channel. It turns single-cycle action strobes into interrupt post and clear requests toward the channel. The strobes are a select-register write, a status-register read, a command write, PIO data ready in either direction, command completion, DMA start, DMA completion, DMA abort and command error. It also issues a command-start pulse, a DMA-complete notice and a seek-status bit. Interrupt delivery is masked by the interrupt-disable bit (`nIenBit`, 1 = masked). A status read is the acknowledge that retires an interrupt, both in the idle state and in the data-ready states.

The drive considers itself selected only when the channel select bit equals the slot it was built for (parameter `DEV_SLOT`). If the drive is deselected while an interrupt is outstanding, the channel-side request is withdrawn. The interrupt is still owed, however, and it is posted again when the drive is reselected with interrupts enabled. Post and clear requests are one-cycle registered pulses. The channel-visible pending flag follows one clock after the pulse.

Top module: `ata_dev_irq_fsm`

## Requirements
- R1: After reset all pulses, `irqPending`, `seekStatus` and `dmaAborted` are 0. `devPhase` is 0 (selected idle) when `DEV_SLOT` is 0 and 2 (not selected) otherwise. Phase codes: 0 selected idle, 1 selected with interrupt, 2 not selected, 3 command busy, 4 read data ready with interrupt, 5 read transfer, 6 write data ready with interrupt, 7 write transfer, 8 DMA transfer.
- R2: A command write in phase 0 or 1 gives `cmdStartPulse` and phase 3 one clock later. In phase 1 it also gives `irqClearPulse`.
- R3: Command completion (or a command error outside DMA) in phase 3, 5 or 7 moves to phase 1 with `irqPostPulse` when `nIenBit` is 0. It moves to phase 0 with no post when `nIenBit` is 1.
- R4: In phase 1, a status read or `nIenBit` at 1 moves to phase 0 with `irqClearPulse`.
- R5: In phase 1, a select write naming the other slot moves to phase 2 with `irqClearPulse`. This has priority over a status read in the same cycle, and the interrupt stays owed.
- R6: In phase 2, a select write naming this slot moves to phase 1 with `irqPostPulse` when an interrupt is owed and `nIenBit` is 0. Otherwise it moves to phase 0 with no post.
- R7: PIO read data ready in phase 3 or 5 enters phase 4 with a post when `nIenBit` is 0. A status read then gives phase 5 and a clear. With `nIenBit` at 1 it goes straight to phase 5.
- R8: PIO write data ready mirrors R7, using phases 6 and 7.
- R9: A DMA start in phase 3 enters phase 8. DMA completion then sets `seekStatus`, gives `dmaDonePulse` and follows the R3 masking rule.
- R10: A DMA abort in phase 8 sets `dmaAborted`. A command error in phase 8 acts like DMA completion and also clears `dmaAborted`.
- R11: `irqPending` becomes 1 one clock after `irqPostPulse` and 0 one clock after `irqClearPulse`. A post never comes while pending, and a clear never comes while not pending.
- R12: A select write whose `chanSelBit` differs from `DEV_SLOT` moves phase 0 to phase 2. A command write in phase 2 is ignored (no start pulse, phase stays 2).
- R13: `cmdStartPulse` clears `seekStatus` in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| selWrStb | input | 1 | Select register write |
| chanSelBit | input | 1 | Slot named by the channel select bit |
| statRdStb | input | 1 | Status register read |
| cmdWrStb | input | 1 | Command register write |
| pioInRdy | input | 1 | PIO read data ready |
| pioOutRdy | input | 1 | PIO write data ready |
| cmdDoneStb | input | 1 | Command completion |
| dmaGoStb | input | 1 | DMA transfer start |
| dmaDoneStb | input | 1 | DMA transfer completion |
| dmaAbortStb | input | 1 | DMA abort request |
| cmdErrStb | input | 1 | Command error |
| nIenBit | input | 1 | Interrupt disable (1 = masked) |
| irqPostPulse | output | 1 | Interrupt post request to the channel |
| irqClearPulse | output | 1 | Interrupt clear request to the channel |
| cmdStartPulse | output | 1 | Command start |
| dmaDonePulse | output | 1 | DMA-complete notice to the channel |
| seekStatus | output | 1 | Seek-complete status bit |
| irqPending | output | 1 | Registered pending interrupt flag |
| dmaAborted | output | 1 | DMA aborted flag |
| devPhase | output | 4 | Current phase code |

## Verification
The deselect and the status-read acknowledge can both arrive in the same cycle while an interrupt is outstanding. The bench asserts both strobes together in phase 1. It expects exactly one clear pulse and phase 2, and it then reselects to confirm the re-post, which shows that deselect won and the interrupt stayed owed. The bench also places post and clear pulses back to back through a command write that follows an acknowledged interrupt. This exercises the one-clock lag of the pending flag against both requests.

// File: rtl/ata_irq_pkg.sv
package ata_irq_pkg;

  localparam int PHASE_W = 4;

  typedef enum logic [PHASE_W-1:0] {
    PH_IDLE_S   = 4'd0,
    PH_IDLE_SI  = 4'd1,
    PH_IDLE_NS  = 4'd2,
    PH_BUSY     = 4'd3,
    PH_DRDY_IN  = 4'd4,
    PH_XFER_IN  = 4'd5,
    PH_DRDY_OUT = 4'd6,
    PH_XFER_OUT = 4'd7,
    PH_DMA      = 4'd8
  } phase_e;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic post;
    logic clear;
    logic ack;
    logic start;
    logic dmaDone;
    logic seekSet;
    logic abortSet;
    logic abortClr;
  } ctrl_strb_t;

endpackage

// File: rtl/ata_irq_ctrl.sv
module ata_irq_ctrl
  import ata_irq_pkg::*;
#(
  parameter bit DEV_SLOT = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       selWrStb,
  input  logic       chanSelBit,
  input  logic       statRdStb,
  input  logic       cmdWrStb,
  input  logic       pioInRdy,
  input  logic       pioOutRdy,
  input  logic       cmdDoneStb,
  input  logic       dmaGoStb,
  input  logic       dmaDoneStb,
  input  logic       dmaAbortStb,
  input  logic       cmdErrStb,
  input  logic       nIenBit,
  input  logic       irqOwed,
  output phase_e     phase,
  output ctrl_strb_t strb
);

  localparam phase_e RESET_PHASE = (DEV_SLOT == 1'b0) ? PH_IDLE_S : PH_IDLE_NS;

  phase_e phaseNx;
  logic   selNow;

  assign selNow = (chanSelBit == DEV_SLOT);

  always_comb begin
    phaseNx = phase;
    strb    = '0;
    unique case (phase)
      PH_IDLE_SI: begin
        if (selWrStb && !selNow) begin
          phaseNx    = PH_IDLE_NS;
          strb.clear = 1'b1;
        end else if (statRdStb || nIenBit) begin
          phaseNx    = PH_IDLE_S;
          strb.clear = 1'b1;
          strb.ack   = 1'b1;
        end else if (cmdWrStb) begin
          phaseNx    = PH_BUSY;
          strb.clear = 1'b1;
          strb.ack   = 1'b1;
          strb.start = 1'b1;
        end
      end
      PH_IDLE_NS: begin
        if (selWrStb && selNow) begin
          if (!nIenBit && irqOwed) begin
            phaseNx   = PH_IDLE_SI;
            strb.post = 1'b1;
          end else begin
            phaseNx  = PH_IDLE_S;
            strb.ack = 1'b1;
          end
        end
      end
      PH_IDLE_S: begin
        if (selWrStb && !selNow) begin
          phaseNx = PH_IDLE_NS;
        end else if (cmdWrStb) begin
          phaseNx    = PH_BUSY;
          strb.start = 1'b1;
        end
      end
      PH_BUSY: begin
        if (dmaGoStb) begin
          phaseNx = PH_DMA;
        end else if (pioInRdy) begin
          phaseNx   = nIenBit ? PH_XFER_IN : PH_DRDY_IN;
          strb.post = !nIenBit;
        end else if (pioOutRdy) begin
          phaseNx   = nIenBit ? PH_XFER_OUT : PH_DRDY_OUT;
          strb.post = !nIenBit;
        end else if (cmdDoneStb || cmdErrStb) begin
          phaseNx   = nIenBit ? PH_IDLE_S : PH_IDLE_SI;
          strb.post = !nIenBit;
        end
      end
      PH_DRDY_IN: begin
        if (statRdStb) begin
          phaseNx    = PH_XFER_IN;
          strb.clear = 1'b1;
          strb.ack   = 1'b1;
        end
      end
      PH_DRDY_OUT: begin
        if (statRdStb) begin
          phaseNx    = PH_XFER_OUT;
          strb.clear = 1'b1;
          strb.ack   = 1'b1;
        end
      end
      PH_XFER_IN: begin
        if (pioInRdy) begin
          phaseNx   = nIenBit ? PH_XFER_IN : PH_DRDY_IN;
          strb.post = !nIenBit;
        end else if (cmdDoneStb || cmdErrStb) begin
          phaseNx   = nIenBit ? PH_IDLE_S : PH_IDLE_SI;
          strb.post = !nIenBit;
        end
      end
      PH_XFER_OUT: begin
        if (pioOutRdy) begin
          phaseNx   = nIenBit ? PH_XFER_OUT : PH_DRDY_OUT;
          strb.post = !nIenBit;
        end else if (cmdDoneStb || cmdErrStb) begin
          phaseNx   = nIenBit ? PH_IDLE_S : PH_IDLE_SI;
          strb.post = !nIenBit;
        end
      end
      PH_DMA: begin
        if (cmdErrStb || dmaDoneStb) begin
          phaseNx       = nIenBit ? PH_IDLE_S : PH_IDLE_SI;
          strb.post     = !nIenBit;
          strb.seekSet  = 1'b1;
          strb.dmaDone  = 1'b1;
          strb.abortClr = cmdErrStb;
        end else if (dmaAbortStb) begin
          strb.abortSet = 1'b1;
        end
      end
      default: phaseNx = RESET_PHASE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= RESET_PHASE;
    else        phase <= phaseNx;
  end

endmodule

// File: rtl/ata_irq_dpath.sv
module ata_irq_dpath
  import ata_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ctrl_strb_t strb,
  output logic       irqPostPulse,
  output logic       irqClearPulse,
  output logic       cmdStartPulse,
  output logic       dmaDonePulse,
  output logic       seekStatus,
  output logic       irqPending,
  output logic       irqOwed,
  output logic       dmaAborted
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irqPostPulse  <= 1'b0;
      irqClearPulse <= 1'b0;
      cmdStartPulse <= 1'b0;
      dmaDonePulse  <= 1'b0;
    end else begin
      irqPostPulse  <= strb.post;
      irqClearPulse <= strb.clear;
      cmdStartPulse <= strb.start;
      dmaDonePulse  <= strb.dmaDone;
    end
  end

  // Channel-visible flag lags the request pulse by one clock
  always_ff @(posedge clk) begin
    if (!rst_n)             irqPending <= 1'b0;
    else if (irqPostPulse)  irqPending <= 1'b1;
    else if (irqClearPulse) irqPending <= 1'b0;
  end

  // Owed interrupt survives deselection; only an acknowledge retires it
  always_ff @(posedge clk) begin
    if (!rst_n)        irqOwed <= 1'b0;
    else if (strb.post) irqOwed <= 1'b1;
    else if (strb.ack)  irqOwed <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            seekStatus <= 1'b0;
    else if (strb.start)   seekStatus <= 1'b0;
    else if (strb.seekSet) seekStatus <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             dmaAborted <= 1'b0;
    else if (strb.abortClr) dmaAborted <= 1'b0;
    else if (strb.abortSet) dmaAborted <= 1'b1;
  end

endmodule

// File: rtl/ata_dev_irq_fsm.sv
module ata_dev_irq_fsm
  import ata_irq_pkg::*;
#(
  parameter bit DEV_SLOT = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               selWrStb,
  input  logic               chanSelBit,
  input  logic               statRdStb,
  input  logic               cmdWrStb,
  input  logic               pioInRdy,
  input  logic               pioOutRdy,
  input  logic               cmdDoneStb,
  input  logic               dmaGoStb,
  input  logic               dmaDoneStb,
  input  logic               dmaAbortStb,
  input  logic               cmdErrStb,
  input  logic               nIenBit,
  output logic               irqPostPulse,
  output logic               irqClearPulse,
  output logic               cmdStartPulse,
  output logic               dmaDonePulse,
  output logic               seekStatus,
  output logic               irqPending,
  output logic               dmaAborted,
  output logic [PHASE_W-1:0] devPhase
);

  phase_e     phase;
  ctrl_strb_t strb;
  logic       irqOwed;

  ata_irq_ctrl #(.DEV_SLOT(DEV_SLOT)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .selWrStb   (selWrStb),
    .chanSelBit (chanSelBit),
    .statRdStb  (statRdStb),
    .cmdWrStb   (cmdWrStb),
    .pioInRdy   (pioInRdy),
    .pioOutRdy  (pioOutRdy),
    .cmdDoneStb (cmdDoneStb),
    .dmaGoStb   (dmaGoStb),
    .dmaDoneStb (dmaDoneStb),
    .dmaAbortStb(dmaAbortStb),
    .cmdErrStb  (cmdErrStb),
    .nIenBit    (nIenBit),
    .irqOwed    (irqOwed),
    .phase      (phase),
    .strb       (strb)
  );

  ata_irq_dpath dpath_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .irqPostPulse (irqPostPulse),
    .irqClearPulse(irqClearPulse),
    .cmdStartPulse(cmdStartPulse),
    .dmaDonePulse (dmaDonePulse),
    .seekStatus   (seekStatus),
    .irqPending   (irqPending),
    .irqOwed      (irqOwed),
    .dmaAborted   (dmaAborted)
  );

  assign devPhase = phase;

endmodule

// File: rtl/ata_dev_irq_chk.sv
module ata_dev_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       nIenBit,
  input logic       irqPostPulse,
  input logic       irqClearPulse,
  input logic       cmdStartPulse,
  input logic       dmaDonePulse,
  input logic       seekStatus,
  input logic       irqPending,
  input logic [3:0] devPhase
);

  // R11: no post on top of a pending interrupt
  p_post_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irqPostPulse |-> !irqPending);

  // R11: no clear without a pending interrupt
  p_clear_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irqClearPulse |-> irqPending);

  // R11: pending flag follows the post one clock later
  p_pend_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irqPostPulse |=> irqPending);

  // R11: pending flag drops one clock after the clear
  p_pend_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irqClearPulse |=> !irqPending);

  // R3: a post is only produced with interrupts enabled
  p_post_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irqPostPulse |-> !$past(nIenBit));

  // R2: command start always lands in the busy phase
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmdStartPulse |-> (devPhase == 4'd3));

  // R9: the DMA-complete notice comes with the seek bit set
  p_dma_seek_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dmaDonePulse |-> seekStatus);

  // R13: command start clears the seek bit
  p_start_seek_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cmdStartPulse |-> !seekStatus);

endmodule

bind ata_dev_irq_fsm ata_dev_irq_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .nIenBit      (nIenBit),
  .irqPostPulse (irqPostPulse),
  .irqClearPulse(irqClearPulse),
  .cmdStartPulse(cmdStartPulse),
  .dmaDonePulse (dmaDonePulse),
  .seekStatus   (seekStatus),
  .irqPending   (irqPending),
  .devPhase     (devPhase)
);

// File: tb/ata_dev_irq_fsm_tb_top.sv
module ata_dev_irq_fsm_tb_top;

  localparam int A_SEL  = 1;
  localparam int A_STAT = 2;
  localparam int A_CMD  = 4;
  localparam int A_PIN  = 8;
  localparam int A_POUT = 16;
  localparam int A_DONE = 32;
  localparam int A_DGO  = 64;
  localparam int A_DDN  = 128;
  localparam int A_ABRT = 256;
  localparam int A_ERR  = 512;

  typedef struct {
    logic [3:0] ph;
    logic [6:0] fl;  // post clr start ddn seek abrt pend
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic selWrStb = 0, chanSelBit = 0, statRdStb = 0, cmdWrStb = 0;
  logic pioInRdy = 0, pioOutRdy = 0, cmdDoneStb = 0, dmaGoStb = 0;
  logic dmaDoneStb = 0, dmaAbortStb = 0, cmdErrStb = 0, nIenBit = 0;
  logic irqPostPulse, irqClearPulse, cmdStartPulse, dmaDonePulse;
  logic seekStatus, irqPending, dmaAborted;
  logic [3:0] devPhase;

  int   total = 0;
  int   bad = 0;
  bit   doneFlag = 0;
  exp_t expQ[$];
  logic pendModel = 0, lastPost = 0, lastClr = 0;

  always #2 clk = ~clk;

  ata_dev_irq_fsm #(.DEV_SLOT(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .selWrStb(selWrStb), .chanSelBit(chanSelBit),
    .statRdStb(statRdStb), .cmdWrStb(cmdWrStb), .pioInRdy(pioInRdy),
    .pioOutRdy(pioOutRdy), .cmdDoneStb(cmdDoneStb), .dmaGoStb(dmaGoStb),
    .dmaDoneStb(dmaDoneStb), .dmaAbortStb(dmaAbortStb), .cmdErrStb(cmdErrStb),
    .nIenBit(nIenBit), .irqPostPulse(irqPostPulse), .irqClearPulse(irqClearPulse),
    .cmdStartPulse(cmdStartPulse), .dmaDonePulse(dmaDonePulse),
    .seekStatus(seekStatus), .irqPending(irqPending), .dmaAborted(dmaAborted),
    .devPhase(devPhase)
  );

  // Driver: apply strobes for one cycle, push expectation after the edge
  task automatic step(input int a, input bit sel, input bit nien,
                      input logic [3:0] ph, input bit post, input bit clr,
                      input bit start, input bit ddn, input bit seek,
                      input bit abrt, input string tag);
    exp_t e;
    @(negedge clk);
    selWrStb    = (a & A_SEL)  != 0;
    statRdStb   = (a & A_STAT) != 0;
    cmdWrStb    = (a & A_CMD)  != 0;
    pioInRdy    = (a & A_PIN)  != 0;
    pioOutRdy   = (a & A_POUT) != 0;
    cmdDoneStb  = (a & A_DONE) != 0;
    dmaGoStb    = (a & A_DGO)  != 0;
    dmaDoneStb  = (a & A_DDN)  != 0;
    dmaAbortStb = (a & A_ABRT) != 0;
    cmdErrStb   = (a & A_ERR)  != 0;
    chanSelBit  = sel;
    nIenBit     = nien;
    @(posedge clk);
    if (lastPost) pendModel = 1'b1;
    else if (lastClr) pendModel = 1'b0;
    lastPost = post;
    lastClr  = clr;
    e.ph  = ph;
    e.fl  = {post, clr, start, ddn, seek, abrt, pendModel};
    e.tag = tag;
    expQ.push_back(e);
  endtask

  // Monitor: compare outputs mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        exp_t e;
        logic [6:0] act;
        e = expQ.pop_front();
        act = {irqPostPulse, irqClearPulse, cmdStartPulse, dmaDonePulse,
               seekStatus, dmaAborted, irqPending};
        total++;
        if (act !== e.fl || devPhase !== e.ph) begin
          bad++;
          $display("FAIL %s: phase=%0d flags=%b expected phase=%0d flags=%b",
                   e.tag, devPhase, act, e.ph, e.fl);
        end
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!doneFlag) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    step(0, 0, 0, 4'd0, 0, 0, 0, 0, 0, 0, "R1 reset");
    // R2 command start, R3 completion with post
    step(A_CMD, 0, 0, 4'd3, 0, 0, 1, 0, 0, 0, "R2 cmd start");
    step(A_DONE, 0, 0, 4'd1, 1, 0, 0, 0, 0, 0, "R3 done post");
    step(0, 0, 0, 4'd1, 0, 0, 0, 0, 0, 0, "R11 pend rise");
    step(A_STAT, 0, 0, 4'd0, 0, 1, 0, 0, 0, 0, "R4 status ack");
    step(0, 0, 0, 4'd0, 0, 0, 0, 0, 0, 0, "R11 pend fall");
    // R3 masked completion
    step(A_CMD, 0, 1, 4'd3, 0, 0, 1, 0, 0, 0, "R2 cmd start masked");
    step(A_DONE, 0, 1, 4'd0, 0, 0, 0, 0, 0, 0, "R3 done masked");
    // R5 deselect beats status read, R6 re-post
    step(A_CMD, 0, 0, 4'd3, 0, 0, 1, 0, 0, 0, "R2 cmd");
    step(A_DONE, 0, 0, 4'd1, 1, 0, 0, 0, 0, 0, "R3 post");
    step(A_SEL | A_STAT, 1, 0, 4'd2, 0, 1, 0, 0, 0, 0, "R5 deselect priority");
    step(0, 1, 0, 4'd2, 0, 0, 0, 0, 0, 0, "R5 idle");
    step(A_SEL, 0, 0, 4'd1, 1, 0, 0, 0, 0, 0, "R6 reselect repost");
    step(A_STAT, 0, 0, 4'd0, 0, 1, 0, 0, 0, 0, "R4 status ack");
    // R12 select decode, ignored command, R6 reselect without owed
    step(A_SEL, 1, 0, 4'd2, 0, 0, 0, 0, 0, 0, "R12 deselect idle");
    step(A_CMD, 1, 0, 4'd2, 0, 0, 0, 0, 0, 0, "R12 cmd ignored");
    step(A_SEL, 0, 0, 4'd0, 0, 0, 0, 0, 0, 0, "R6 reselect no owed");
    // R2 command write in phase 1 clears, post/clear back to back
    step(A_CMD, 0, 0, 4'd3, 0, 0, 1, 0, 0, 0, "R2 cmd");
    step(A_DONE, 0, 0, 4'd1, 1, 0, 0, 0, 0, 0, "R3 post");
    step(A_CMD, 0, 0, 4'd3, 0, 1, 1, 0, 0, 0, "R2 cmd clears irq");
    // R7 PIO read
    step(A_PIN, 0, 0, 4'd4, 1, 0, 0, 0, 0, 0, "R7 read ready post");
    step(A_STAT, 0, 0, 4'd5, 0, 1, 0, 0, 0, 0, "R7 read ack");
    step(A_PIN, 0, 1, 4'd5, 0, 0, 0, 0, 0, 0, "R7 read masked");
    step(A_DONE, 0, 1, 4'd0, 0, 0, 0, 0, 0, 0, "R3 done masked");
    // R8 PIO write
    step(A_CMD, 0, 0, 4'd3, 0, 0, 1, 0, 0, 0, "R2 cmd");
    step(A_POUT, 0, 0, 4'd6, 1, 0, 0, 0, 0, 0, "R8 write ready post");
    step(A_STAT, 0, 0, 4'd7, 0, 1, 0, 0, 0, 0, "R8 write ack");
    step(A_POUT, 0, 1, 4'd7, 0, 0, 0, 0, 0, 0, "R8 write masked");
    step(A_DONE, 0, 0, 4'd1, 1, 0, 0, 0, 0, 0, "R3 done from write");
    step(A_STAT, 0, 0, 4'd0, 0, 1, 0, 0, 0, 0, "R4 status ack");
    // R9 DMA completion
    step(A_CMD, 0, 0, 4'd3, 0, 0, 1, 0, 0, 0, "R2 cmd");
    step(A_DGO, 0, 0, 4'd8, 0, 0, 0, 0, 0, 0, "R9 dma enter");
    step(A_DDN, 0, 0, 4'd1, 1, 0, 0, 1, 1, 0, "R9 dma done");
    step(A_STAT, 0, 0, 4'd0, 0, 1, 0, 0, 1, 0, "R4 status ack");
    // R13 seek cleared, R10 abort and error
    step(A_CMD, 0, 0, 4'd3, 0, 0, 1, 0, 0, 0, "R13 seek cleared");
    step(A_DGO, 0, 0, 4'd8, 0, 0, 0, 0, 0, 0, "R9 dma enter");
    step(A_ABRT, 0, 0, 4'd8, 0, 0, 0, 0, 0, 1, "R10 abort flag");
    step(A_ERR, 0, 1, 4'd0, 0, 0, 0, 1, 1, 0, "R10 error masked");
    // R4 nIEN acknowledge in phase 1
    step(A_CMD, 0, 0, 4'd3, 0, 0, 1, 0, 0, 0, "R13 cmd");
    step(A_DONE, 0, 0, 4'd1, 1, 0, 0, 0, 0, 0, "R3 post");
    step(0, 0, 1, 4'd0, 0, 1, 0, 0, 0, 0, "R4 nien ack");
    step(0, 0, 0, 4'd0, 0, 0, 0, 0, 0, 0, "R11 settled");
    repeat (3) @(negedge clk);
    doneFlag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule